// File: doc/BRIEF.md
# Event-Condition-Action Rule Dispatcher

This block sequences memory traffic without branches or a program counter. It holds a set of small token queues and a table of rules. Each rule names one or two trigger queues, an optional condition, and one action: a load, a store, or a token move. A rule becomes ready when every trigger queue holds a token and the resources its action needs are free. In each cycle the ready rule with the lowest index fires. Firing always consumes the trigger tokens. The action itself is carried out only if the condition holds. When the condition fails, the tokens are discarded, and this is how a loop exits.

Loads go out on a request port with a tag that names the destination queue. Responses may return in any order, and each one is written into the queue its tag names. Before a load is issued, a slot is reserved in its destination queue, so a returning value always has room. Outside producers and consumers reach the queues through a per-queue push port and a per-queue pop port. The rule table is a static configuration input, loaded while the block is idle.

Top module: `eca_dispatch`

## Requirements
- R1: After reset all queues are empty, no queue reports full, no memory request is pending and `idle` is high.
- R2: A rule word holds valid at bit 0, the action at bits [2:1] (0 load, 1 store, 2 move), the first trigger queue A at [3+:QW], the second trigger queue B at [3+QW+:QW], the B-used flag at [3+2QW], the destination queue at [4+2QW+:QW] and the condition enable at [4+3QW]. A move fires in the cycle after A becomes non-empty if the destination has room. It transfers A's head into the destination in FIFO order and consumes B if B is used.
- R3: When the condition is enabled and B is used, the head of B is tested: zero means false. On false, the trigger tokens are still consumed, no action takes place, and `fire_act` is low.
- R4: At most one rule fires per cycle. Among ready rules the lowest index wins, and `fire_idx` reports it.
- R5: A load with a true condition issues a read request on the next cycle. The request carries address = head of A and tag = destination queue index.
- R6: A queue's occupancy plus its reserved load slots never exceeds DEPTH. `q_full` is high exactly when that sum equals DEPTH. A load or move toward a full queue does not fire.
- R7: A store needs tokens in both A (address) and B (data), whatever the B-used flag says. It issues a write request carrying that address and data.
- R8: While a request is valid and not accepted, the request outputs hold their values.
- R9: A response may arrive in any order relative to other responses. Its data is appended to the queue named by its tag.
- R10: `idle` is high when no rule is ready, no load slot is reserved and no request is pending.
- R11: A rule with valid low, or with action code 3, never fires, even when its triggers hold tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rule_cfg | input | NR*RW | Rule table, rule i at bits [i*RW +: RW] |
| ext_push | input | NQ | Per-queue push from outside producers |
| ext_push_data | input | NQ*DW | Push data, queue q at [q*DW +: DW] |
| ext_pop | input | NQ | Per-queue pop by outside consumers |
| q_head | output | NQ*DW | Head token of each queue |
| q_nempty | output | NQ | Queue holds at least one token |
| q_full | output | NQ | Occupancy plus reserved slots equals DEPTH |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | DW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_req_tag | output | QW | Destination queue of a read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_tag | input | QW | Queue the response belongs to |
| mem_rsp_data | input | DW | Response data |
| fire_valid | output | 1 | A rule fires this cycle |
| fire_idx | output | RIW | Index of the firing rule |
| fire_act | output | 1 | The firing rule's condition holds and its action runs |
| idle | output | 1 | Nothing ready, nothing reserved, nothing pending |

## Verification
Four properties are checked in every cycle. Occupancy plus reservations stays within DEPTH. No ready rule below the firing one is passed over. A stalled request holds steady. Every load request and every response refers to a queue that holds a reservation. Data movement cannot be shown by properties and needs the bench's scenarios: FIFO order through a move, tokens dropped on a false condition, out-of-order response routing, and the store waiting for its data token. The bench also sweeps every combination of four competing rules to confirm the winner and the destination that receives the token.

// File: rtl/eca_pkg.sv
// Shared types for the rule dispatcher.
// Assumes: the action code occupies two bits of each rule word.
package eca_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_MOVE  = 2'd2,
        OP_NONE  = 2'd3
    } eca_op_e;
endpackage

// File: rtl/eca_queue.sv
// Token FIFO for one event queue.
// Allows a push and a pop in the same cycle. A pop of an empty queue and a push
// into a full queue without a pop are ignored; callers keep to the limits.
module eca_queue #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] store_q [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Qualify the requests against the current fill level.
    always_comb begin
        do_pop  = pop && (count != '0);
        do_push = push && ((count != CW'(DEPTH)) || do_pop);
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Token storage, written without reset.
    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_ptr] <= push_data;
    end

    assign head = store_q[rd_ptr];
endmodule

// File: rtl/eca_rule_slot.sv
// Decodes one rule word and decides whether that rule is ready to fire.
// Assumes NQ is a power of two, so every queue field indexes a real queue.
// A rule is ready when its triggers hold tokens and, if its condition holds,
// the resources for its action are free. A false condition needs no resource.
module eca_rule_slot
    import eca_pkg::*;
#(
    parameter int NQ = 8,
    parameter int DW = 16,
    localparam int QW = $clog2(NQ),
    localparam int RW = 5 + 3 * QW
) (
    input  logic [RW-1:0]    rule,
    input  logic [NQ-1:0]    q_nempty,
    input  logic [NQ-1:0]    q_room,
    input  logic [NQ-1:0]    q_mv_room,
    input  logic [NQ*DW-1:0] q_heads,
    input  logic             req_free,
    output logic             ready,
    output eca_op_e          op,
    output logic [QW-1:0]    src_a,
    output logic [QW-1:0]    src_b,
    output logic [QW-1:0]    dst,
    output logic             need_b,
    output logic             cond_ok
);
    logic          valid, use_b, cond_en, trig_ok, res_ok;
    logic [DW-1:0] head_b;

    // Field extraction from the rule word.
    always_comb begin
        valid   = rule[0];
        op      = eca_op_e'(rule[2:1]);
        src_a   = rule[3 +: QW];
        src_b   = rule[3 + QW +: QW];
        use_b   = rule[3 + 2 * QW];
        dst     = rule[4 + 2 * QW +: QW];
        cond_en = rule[4 + 3 * QW];
    end

    // Trigger conjunction and condition test on the second queue's head.
    always_comb begin
        need_b  = use_b || (op == OP_STORE);
        head_b  = q_heads[src_b * DW +: DW];
        trig_ok = q_nempty[src_a] && (!need_b || q_nempty[src_b]);
        cond_ok = !(cond_en && need_b) || (head_b != '0);
    end

    // Resource check for the action that would run.
    always_comb begin
        case (op)
            OP_LOAD:  res_ok = !cond_ok || (q_room[dst] && req_free);
            OP_STORE: res_ok = !cond_ok || req_free;
            OP_MOVE:  res_ok = !cond_ok || q_mv_room[dst];
            default:  res_ok = 1'b0;
        endcase
        ready = valid && (op != OP_NONE) && trig_ok && res_ok;
    end
endmodule

// File: rtl/eca_prio_pick.sv
// Fixed-priority picker: reports the lowest set bit of a request vector.
module eca_prio_pick #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        valid = |req;
    end
endmodule

// File: rtl/eca_dispatch.sv
// Event-condition-action dispatcher: queues, rule slots, picker, request port.
// Assumes: outside pushes target only queues that no rule writes into and no
// load returns to; outside pops target only queues that no rule reads; within a
// rule, A, B and the destination are distinct queues; responses carry tags of
// queues holding a reservation. The rule table changes only while idle.
module eca_dispatch
    import eca_pkg::*;
#(
    parameter int NQ    = 8,
    parameter int NR    = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int QW   = $clog2(NQ),
    localparam int RW   = 5 + 3 * QW,
    localparam int RIW  = (NR > 1) ? $clog2(NR) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NR*RW-1:0] rule_cfg,
    input  logic [NQ-1:0]    ext_push,
    input  logic [NQ*DW-1:0] ext_push_data,
    input  logic [NQ-1:0]    ext_pop,
    output logic [NQ*DW-1:0] q_head,
    output logic [NQ-1:0]    q_nempty,
    output logic [NQ-1:0]    q_full,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [DW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    output logic [QW-1:0]    mem_req_tag,
    input  logic             mem_rsp_valid,
    input  logic [QW-1:0]    mem_rsp_tag,
    input  logic [DW-1:0]    mem_rsp_data,
    output logic             fire_valid,
    output logic [RIW-1:0]   fire_idx,
    output logic             fire_act,
    output logic             idle
);
    logic [CW-1:0] q_cnt [NQ];
    logic [CW-1:0] resv  [NQ];
    logic [DW-1:0] q_hd  [NQ];
    logic [NQ-1:0] q_room, q_mv_room, rsp_hit, q_pop, q_push;
    logic [DW-1:0] q_wdata [NQ];

    logic [NR-1:0] rule_rdy;
    eca_op_e       r_op    [NR];
    logic [QW-1:0] r_a     [NR];
    logic [QW-1:0] r_b     [NR];
    logic [QW-1:0] r_dst   [NR];
    logic          r_needb [NR];
    logic          r_cond  [NR];

    eca_op_e       s_op;
    logic [QW-1:0] s_a, s_b, s_dst;
    logic          s_needb, s_cond;
    logic          req_free, fire_mem, fire_load, fire_move, resv_any;

    // Queues and their occupancy-derived flags.
    for (genvar q = 0; q < NQ; q++) begin : g_q
        eca_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[q]),
            .push_data (q_wdata[q]),
            .pop       (q_pop[q]),
            .head      (q_hd[q]),
            .count     (q_cnt[q])
        );
        assign q_head[q*DW +: DW] = q_hd[q];
        assign q_nempty[q] = (q_cnt[q] != '0);
        assign q_full[q]   = ({1'b0, q_cnt[q]} + {1'b0, resv[q]}) >= (CW + 1)'(DEPTH);
        assign rsp_hit[q]  = mem_rsp_valid && (mem_rsp_tag == QW'(q));
        assign q_room[q]    = !q_full[q];
        assign q_mv_room[q] = !q_full[q] && !rsp_hit[q];
    end

    // Rule slots, one per table entry.
    for (genvar r = 0; r < NR; r++) begin : g_rule
        eca_rule_slot #(.NQ(NQ), .DW(DW)) u_slot (
            .rule      (rule_cfg[r*RW +: RW]),
            .q_nempty  (q_nempty),
            .q_room    (q_room),
            .q_mv_room (q_mv_room),
            .q_heads   (q_head),
            .req_free  (req_free),
            .ready     (rule_rdy[r]),
            .op        (r_op[r]),
            .src_a     (r_a[r]),
            .src_b     (r_b[r]),
            .dst       (r_dst[r]),
            .need_b    (r_needb[r]),
            .cond_ok   (r_cond[r])
        );
    end

    eca_prio_pick #(.N(NR)) u_pick (
        .req   (rule_rdy),
        .valid (fire_valid),
        .idx   (fire_idx)
    );

    // Fields of the winning rule and the kind of work it starts.
    always_comb begin
        s_op      = r_op[fire_idx];
        s_a       = r_a[fire_idx];
        s_b       = r_b[fire_idx];
        s_dst     = r_dst[fire_idx];
        s_needb   = r_needb[fire_idx];
        s_cond    = r_cond[fire_idx];
        fire_act  = fire_valid && s_cond;
        fire_load = fire_act && (s_op == OP_LOAD);
        fire_move = fire_act && (s_op == OP_MOVE);
        fire_mem  = fire_load || (fire_act && (s_op == OP_STORE));
        req_free  = !mem_req_valid || mem_req_ready;
    end

    // Per-queue pop and push steering; a response wins the write port.
    for (genvar q = 0; q < NQ; q++) begin : g_steer
        logic mv_hit;
        assign mv_hit   = fire_move && (s_dst == QW'(q));
        assign q_pop[q] = ext_pop[q]
                        || (fire_valid && (s_a == QW'(q)))
                        || (fire_valid && s_needb && (s_b == QW'(q)));
        assign q_push[q]  = rsp_hit[q] || mv_hit || ext_push[q];
        assign q_wdata[q] = rsp_hit[q] ? mem_rsp_data
                          : mv_hit     ? q_hd[s_a]
                          :              ext_push_data[q*DW +: DW];

        // Reservation count: up on a load issued here, down on its return.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resv[q] <= '0;
            end else begin
                resv[q] <= resv[q]
                         + CW'(fire_load && (s_dst == QW'(q)))
                         - CW'(rsp_hit[q]);
            end
        end
    end

    // Request register toward memory, held while the memory stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
            mem_req_tag   <= '0;
        end else if (fire_mem) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= (s_op == OP_STORE);
            mem_req_addr  <= q_hd[s_a];
            mem_req_wdata <= (s_op == OP_STORE) ? q_hd[s_b] : '0;
            mem_req_tag   <= s_dst;
        end else if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
        end
    end

    // Quiescence: nothing ready, nothing reserved, nothing pending.
    always_comb begin
        resv_any = 1'b0;
        for (int q = 0; q < NQ; q++) resv_any = resv_any || (resv[q] != '0);
        idle = !fire_valid && !resv_any && !mem_req_valid;
    end
endmodule

// File: rtl/eca_dispatch_chk.sv
// Property checker for the dispatcher, attached to every instance by bind.
module eca_dispatch_chk #(
    parameter int NQ    = 8,
    parameter int NR    = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int QW   = $clog2(NQ),
    localparam int RIW  = (NR > 1) ? $clog2(NR) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic           mem_req_we,
    input logic [DW-1:0]  mem_req_addr,
    input logic [DW-1:0]  mem_req_wdata,
    input logic [QW-1:0]  mem_req_tag,
    input logic           mem_rsp_valid,
    input logic [QW-1:0]  mem_rsp_tag,
    input logic           fire_valid,
    input logic [RIW-1:0] fire_idx,
    input logic [NR-1:0]  rule_rdy,
    input logic           idle,
    input logic [CW-1:0]  cnt  [NQ],
    input logic [CW-1:0]  resv [NQ]
);
    logic [NR-1:0] below;
    assign below = rule_rdy & ((NR'(1) << fire_idx) - NR'(1));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
        && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_tag)); // R8

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> (below == '0)); // R4

    AST_LOAD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_we |-> resv[mem_req_tag] != '0); // R5

    AST_RSP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> resv[mem_rsp_tag] != '0); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> !mem_req_valid); // R10

    for (genvar q = 0; q < NQ; q++) begin : g_ovf
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, cnt[q]} + {1'b0, resv[q]}) <= (CW + 1)'(DEPTH)); // R6
    end
endmodule

bind eca_dispatch eca_dispatch_chk #(.NQ(NQ), .NR(NR), .DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_tag   (mem_req_tag),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_tag   (mem_rsp_tag),
    .fire_valid    (fire_valid),
    .fire_idx      (fire_idx),
    .rule_rdy      (rule_rdy),
    .idle          (idle),
    .cnt           (q_cnt),
    .resv          (resv)
);

// File: tb/test_eca_dispatch.sv
`timescale 1ns/1ps
// Scenario bench for the dispatcher with its default configuration.
module test_eca_dispatch;
    localparam int NQ = 8, NR = 8, DEPTH = 4, DW = 16;
    localparam int QW = 3, RW = 5 + 3 * QW, RIW = 3;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, MV = 2'd2, NOP = 2'd3;

    logic             clk = 0, rst_n = 0;
    logic [NR*RW-1:0] rule_cfg = '0;
    logic [NQ-1:0]    ext_push = '0, ext_pop = '0;
    logic [NQ*DW-1:0] ext_push_data = '0;
    logic [NQ*DW-1:0] q_head;
    logic [NQ-1:0]    q_nempty, q_full;
    logic             mem_req_valid, mem_req_we, mem_req_ready = 1;
    logic [DW-1:0]    mem_req_addr, mem_req_wdata, mem_rsp_data = '0;
    logic [QW-1:0]    mem_req_tag, mem_rsp_tag = '0;
    logic             mem_rsp_valid = 0;
    logic             fire_valid, fire_act, idle;
    logic [RIW-1:0]   fire_idx;

    int n_chk = 0, n_fail = 0, cyc = 0, n_req = 0;
    int rq_addr [64], rq_tag [64], rq_we [64], rq_wd [64];

    eca_dispatch i_eca_dispatch (.*);

    always #2.5 clk = ~clk;

    function automatic logic [RW-1:0] mk(input logic v, input logic [1:0] op, input int a,
                                         input int b, input logic ub, input int d, input logic ce);
        return {ce, QW'(d), ub, QW'(b), QW'(a), op, v};
    endfunction

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic push1(input int q, input int v);
        ext_push[q] = 1'b1;
        ext_push_data[q*DW +: DW] = DW'(v);
        @(negedge clk);
        ext_push[q] = 1'b0;
    endtask

    task automatic push2(input int qa, input int va, input int qb, input int vb);
        ext_push[qa] = 1'b1;
        ext_push[qb] = 1'b1;
        ext_push_data[qa*DW +: DW] = DW'(va);
        ext_push_data[qb*DW +: DW] = DW'(vb);
        @(negedge clk);
        ext_push[qa] = 1'b0;
        ext_push[qb] = 1'b0;
    endtask

    task automatic pop_chk(input string req, input int q, input int exp);
        int hd;
        hd = int'(q_head[q*DW +: DW]);
        chk(req, q_nempty[q] && hd == exp, hd, exp);
        ext_pop[q] = 1'b1;
        @(negedge clk);
        ext_pop[q] = 1'b0;
    endtask

    task automatic respond(input int k);
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = QW'(rq_tag[k]);
        mem_rsp_data  = DW'(rq_addr[k] ^ 16'h5A5A);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    // Record every accepted request shortly after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_req_valid && mem_req_ready && n_req < 64) begin
            rq_addr[n_req] = int'(mem_req_addr);
            rq_tag[n_req]  = int'(mem_req_tag);
            rq_we[n_req]   = int'(mem_req_we);
            rq_wd[n_req]   = int'(mem_req_wdata);
            n_req++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 idle", idle == 1'b1, idle, 1);
        chk("R1 empty", q_nempty == '0, q_nempty, 0);
        chk("R1 full", q_full == '0, q_full, 0);
        chk("R1 req", mem_req_valid == 1'b0, mem_req_valid, 0);

        // R2 unconditional move q0 -> q1 with back-pressure
        rule_cfg[0 +: RW] = mk(1, MV, 0, 0, 0, 1, 0);
        for (int v = 0; v < 6; v++) begin
            push1(0, 100 + v);
            if (v < 4) chk("R2 fires next cycle", fire_valid && fire_idx == 0, fire_valid, 1);
        end
        chk("R6 dst full", q_full[1] == 1'b1, q_full[1], 1);
        chk("R2 blocked on full dst", fire_valid == 1'b0, fire_valid, 0);
        for (int v = 0; v < 6; v++) pop_chk("R2 fifo order", 1, 100 + v);
        chk("R2 source drained", q_nempty[0] == 1'b0, q_nempty[0], 0);

        // R3 conditional move: control value zero drops the data token
        rule_cfg = '0;
        rule_cfg[0 +: RW] = mk(1, MV, 2, 3, 1, 4, 1);
        for (int i = 0; i < 9; i++) begin
            push2(2, 200 + i, 3, i % 3);
            chk("R3 act flag", fire_valid && fire_act == (i % 3 != 0), fire_act, int'(i % 3 != 0));
            tick();
            if (i % 3 != 0) pop_chk("R3 forwarded", 4, 200 + i);
            else chk("R3 dropped", q_nempty[4] == 1'b0, q_nempty[4], 0);
            chk("R3 triggers consumed", q_nempty[3:2] == 2'b00, q_nempty[3:2], 0);
        end

        // R4 / R11 fixed priority over every subset of four competing moves
        for (int m = 0; m < 16; m++) begin
            int low;
            low = -1;
            for (int b = 3; b >= 0; b--) if (m[b]) low = b;
            rule_cfg = '0;
            for (int r = 0; r < 4; r++) rule_cfg[r*RW +: RW] = mk(m[r], MV, 0, 0, 0, 1 + r, 0);
            rule_cfg[4*RW +: RW] = mk(1, NOP, 0, 0, 0, 5, 0);
            rule_cfg[5*RW +: RW] = mk(0, MV, 0, 0, 0, 5, 0);
            push1(0, 777);
            if (low >= 0) begin
                chk("R4 lowest wins", fire_valid && fire_idx == low, fire_idx, low);
                tick();
                chk("R4 single dst", q_nempty[5:1] == 5'(1 << low), q_nempty[5:1], 1 << low);
                pop_chk("R4 token", 1 + low, 777);
            end else begin
                chk("R11 no fire", fire_valid == 1'b0, fire_valid, 0);
                tick();
                chk("R11 nothing moved", q_nempty[5:1] == '0, q_nempty[5:1], 0);
                pop_chk("R11 token kept", 0, 777);
            end
        end

        // R5 / R9 loads, responses returned out of order
        rule_cfg = '0;
        rule_cfg[0 +: RW] = mk(1, LD, 5, 0, 0, 6, 0);
        base = n_req;
        push1(5, 16'h10);
        push1(5, 16'h20);
        push1(5, 16'h30);
        tick(3);
        chk("R5 request count", n_req == base + 3, n_req - base, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R5 read addr", rq_addr[base+k] == 16 * (k + 1), rq_addr[base+k], 16 * (k + 1));
            chk("R5 read tag", rq_we[base+k] == 0 && rq_tag[base+k] == 6, rq_tag[base+k], 6);
        end
        chk("R10 busy while outstanding", idle == 1'b0, idle, 0);
        respond(base + 2);
        respond(base + 0);
        respond(base + 1);
        pop_chk("R9 first returned", 6, 16'h30 ^ 16'h5A5A);
        pop_chk("R9 second returned", 6, 16'h10 ^ 16'h5A5A);
        pop_chk("R9 third returned", 6, 16'h20 ^ 16'h5A5A);
        chk("R10 idle after returns", idle == 1'b1, idle, 1);

        // R6 reservations limit loads in flight toward one queue
        base = n_req;
        for (int j = 0; j < 6; j++) push1(5, 16'h100 + j);
        tick(2);
        chk("R6 loads capped", n_req == base + 4, n_req - base, 4);
        chk("R6 full by reservation", q_full[6] == 1'b1, q_full[6], 1);
        chk("R6 no fire when full", fire_valid == 1'b0, fire_valid, 0);
        for (int k = 0; k < 6; k++) begin
            for (int t = 0; t < 20 && n_req <= base + k; t++) tick();
            respond(base + k);
            pop_chk("R6 returned data", 6, (16'h100 + k) ^ 16'h5A5A);
        end
        tick(2);
        chk("R6 all loads issued", n_req == base + 6, n_req - base, 6);

        // R7 / R8 store waits for its data token, then holds under stall
        rule_cfg = '0;
        rule_cfg[0 +: RW] = mk(1, ST, 0, 1, 0, 0, 0);
        mem_req_ready = 1'b0;
        base = n_req;
        push1(0, 16'h44);
        tick(2);
        chk("R7 waits for data", mem_req_valid == 1'b0, mem_req_valid, 0);
        push1(1, 16'h99);
        tick();
        chk("R7 write addr", mem_req_valid && mem_req_we && mem_req_addr == 16'h44, mem_req_addr, 16'h44);
        chk("R7 write data", mem_req_wdata == 16'h99, mem_req_wdata, 16'h99);
        tick(3);
        chk("R8 held", mem_req_valid && mem_req_addr == 16'h44 && mem_req_wdata == 16'h99, mem_req_addr, 16'h44);
        mem_req_ready = 1'b1;
        tick(2);
        chk("R7 accepted once", n_req == base + 1 && rq_we[base] == 1, n_req - base, 1);
        chk("R8 released", mem_req_valid == 1'b0, mem_req_valid, 0);

        // R3 load with a false condition issues nothing but consumes tokens
        rule_cfg = '0;
        rule_cfg[0 +: RW] = mk(1, LD, 5, 7, 1, 6, 1);
        base = n_req;
        push2(5, 16'h300, 7, 0);
        tick(2);
        chk("R3 no load on false", n_req == base, n_req - base, 0);
        chk("R3 load tokens consumed", q_nempty[5] == 1'b0 && q_nempty[7] == 1'b0, q_nempty[7], 0);
        push2(5, 16'h301, 7, 1);
        tick(2);
        chk("R3 load on true", n_req == base + 1 && rq_addr[base] == 16'h301, rq_addr[base], 16'h301);
        respond(base);
        pop_chk("R3 load data", 6, 16'h301 ^ 16'h5A5A);

        summary();
        $finish;
    end
endmodule